// File: doc/BRIEF.md
# Multi-core run/stop power controller

This block starts and halts a group of processors on behalf of software through a small memory-mapped register file. A write to the start register carries a bitmask. For each selected processor that is neither running nor already starting, the block raises a reset request and holds it until that processor acknowledges. Only then does the processor's running bit set, together with its run enable. A write to the halt register carries a bitmask too. For each selected processor that is running, it issues a one-cycle halt request and clears the running bit at the same edge. Software reads the running bitmask from a status register.

The three registers appear twice, once in a local window at base 0x000 and once in an alternate window at base 0x100. The two windows behave identically. When block reset is released, nothing is running. The processors named in a start-at-reset parameter mask then go through the ordinary start handshake. If that mask names a processor beyond the processor count, elaboration is rejected. Written masks are trimmed to the processor count.

The register bus is a 64-bit valid/ready interface that always accepts. A read returns its data one cycle after it is issued, marked by a response valid.

Top module: `vp_run_ctrl`

## Requirements
- R1: Bits of a start or halt write mask at positions NUM_VP and above have no effect, and status read data is zero above bit NUM_VP-1.
- R2: A start write raises `reset_req[i]` one cycle later for each selected processor in the idle state, and leaves processors that are already running unchanged.
- R3: `reset_req[i]` stays high until `reset_ack[i]` is sampled high. At that edge `reset_req[i]` falls and `run_en[i]` rises, and `run_en[i]` never rises without that acknowledge.
- R4: A halt write to a running processor gives a single-cycle `halt_req[i]` pulse one cycle later, and `run_en[i]` is low from that same cycle. A halt write to a processor that is not running produces no pulse.
- R5: A read of the status offset returns the running bitmask with `rsp_valid` high one cycle after the request, and `rsp_valid` is high only then.
- R6: The start, halt and status registers sit at offsets 0x00, 0x08 and 0x10 inside a window at base 0x000 and inside a second window at base 0x100. Both windows act identically.
- R7: After reset is released no processor is running, and every processor whose bit is set in START_MASK has `reset_req` high and waits for its acknowledge like a normal start.
- R8: Writes to any other address change nothing. Reads of any other address, the start and halt offsets included, return zero.
- R9: A further start write to a processor that is waiting for its acknowledge keeps `reset_req[i]` high without a break and changes nothing else.
- R10: A halt write to a processor that is waiting for its acknowledge cancels the start. `reset_req[i]` drops, no halt pulse is produced, and a later `reset_ack[i]` does not set `run_en[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data (processor bitmask) |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | DATA_W | Read data |
| reset_ack | input | NUM_VP | Per-processor reset-done acknowledge |
| reset_req | output | NUM_VP | Per-processor reset request (start pending) |
| run_en | output | NUM_VP | Per-processor running / run enable |
| halt_req | output | NUM_VP | Per-processor one-cycle halt request |

## Verification
The bench builds the block with NUM_VP = 4 and START_MASK = 0x5. The start-at-reset path therefore has to pick out two processors and leave two idle. Masks with bits 4 to 7 set then reach the trimming logic. With four slots, one write can find processors in the idle, starting and running states together, which shows that each slot checks its own state. The default single-processor build can exercise none of these mixed cases.

// File: rtl/vprc_pkg.sv
// Package: shared register offsets, slot state encoding and the decoded
// bus command used by the run/stop controller.
// Assumes: byte addresses, windows 256 bytes apart.
package vprc_pkg;

    localparam logic [7:0] OFS_START  = 8'h00;
    localparam logic [7:0] OFS_HALT   = 8'h08;
    localparam logic [7:0] OFS_STATUS = 8'h10;
    localparam int         WIN_SHIFT  = 8;
    localparam int         NUM_WIN    = 2;

    typedef enum logic [1:0] {
        SLOT_IDLE    = 2'd0,
        SLOT_PENDING = 2'd1,
        SLOT_RUNNING = 2'd2
    } slot_state_t;

    typedef struct packed {
        logic start_wr;
        logic halt_wr;
        logic status_rd;
        logic any_rd;
    } bus_cmd_t;

endpackage

// File: rtl/vprc_decode.sv
// Module: address decoder for the two aliased register windows.
// Assumes: ADDR_W > WIN_SHIFT; window index taken from address bits above
// the 256-byte window, offset from the low byte; exact offset match only.
module vprc_decode
    import vprc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output bus_cmd_t          cmd
);
    localparam int WIN_W = ADDR_W - WIN_SHIFT;

    logic [WIN_W-1:0] win;
    logic [7:0]       ofs;
    logic             win_ok;

    assign win = req_addr[ADDR_W-1:WIN_SHIFT];
    assign ofs = req_addr[WIN_SHIFT-1:0];

    // Purpose: accept either window and decode the register offset.
    always_comb begin
        win_ok        = (win < WIN_W'(NUM_WIN));
        cmd.start_wr  = req_valid &&  req_write && win_ok && (ofs == OFS_START);
        cmd.halt_wr   = req_valid &&  req_write && win_ok && (ofs == OFS_HALT);
        cmd.status_rd = req_valid && !req_write && win_ok && (ofs == OFS_STATUS);
        cmd.any_rd    = req_valid && !req_write;
    end

endmodule

// File: rtl/vprc_slot.sv
// Module: per-processor run/stop state machine.
// Idle -> pending on a start command; pending -> running on acknowledge;
// pending -> idle on a halt command (cancel); running -> idle on a halt
// command with a one-cycle halt pulse. Assumes start and halt commands
// never arrive together (single bus).
module vprc_slot
    import vprc_pkg::*;
#(
    parameter bit START_ON_RESET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_cmd,
    input  logic halt_cmd,
    input  logic ack,
    output logic reset_req,
    output logic run_en,
    output logic halt_req
);
    slot_state_t state;

    // Purpose: advance the slot state and produce the halt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= START_ON_RESET ? SLOT_PENDING : SLOT_IDLE;
            halt_req <= 1'b0;
        end else begin
            halt_req <= 1'b0;
            unique case (state)
                SLOT_IDLE: begin
                    if (start_cmd) state <= SLOT_PENDING;
                end
                SLOT_PENDING: begin
                    if (halt_cmd)  state <= SLOT_IDLE;
                    else if (ack)  state <= SLOT_RUNNING;
                end
                SLOT_RUNNING: begin
                    if (halt_cmd) begin
                        state    <= SLOT_IDLE;
                        halt_req <= 1'b1;
                    end
                end
                default: state <= SLOT_IDLE;
            endcase
        end
    end

    assign reset_req = (state == SLOT_PENDING);
    assign run_en    = (state == SLOT_RUNNING);

endmodule

// File: rtl/vprc_readback.sv
// Module: registered read response for the status register.
// Returns the running mask for a status read, zero for any other read.
// Assumes: NUM_VP <= DATA_W.
module vprc_readback
    import vprc_pkg::*;
#(
    parameter int NUM_VP = 1,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_cmd_t          cmd,
    input  logic [NUM_VP-1:0] running,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    // Purpose: capture read data one cycle after a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= cmd.any_rd;
            if (cmd.any_rd)
                rsp_rdata <= cmd.status_rd ? DATA_W'(running) : '0;
        end
    end

endmodule

// File: rtl/vp_run_ctrl.sv
// Module: top of the multi-core run/stop controller.
// Decodes the aliased register windows, trims write masks to NUM_VP,
// fans commands out to one slot per processor and returns status reads.
// Assumes: NUM_VP in 1..DATA_W; START_MASK has no bit at or above NUM_VP.
module vp_run_ctrl
    import vprc_pkg::*;
#(
    parameter int          NUM_VP     = 1,
    parameter logic [63:0] START_MASK = 64'h1,
    parameter int          ADDR_W     = 12,
    parameter int          DATA_W     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [NUM_VP-1:0] reset_ack,
    output logic [NUM_VP-1:0] reset_req,
    output logic [NUM_VP-1:0] run_en,
    output logic [NUM_VP-1:0] halt_req
);
    // Elaboration-time parameter checks.
    if (NUM_VP < 1 || NUM_VP > DATA_W) begin : g_bad_count
        $error("vp_run_ctrl: NUM_VP out of range");
    end
    if (NUM_VP < 64) begin : g_mask_chk
        if ((START_MASK >> NUM_VP) != 64'h0) begin : g_bad_start
            $error("vp_run_ctrl: START_MASK names a processor beyond NUM_VP");
        end
    end

    bus_cmd_t          cmd;
    logic [NUM_VP-1:0] vp_mask;

    assign req_ready = 1'b1;
    assign vp_mask   = req_wdata[NUM_VP-1:0];

    // Mask bits above the processor count are dropped here.
    if (NUM_VP < DATA_W) begin : g_trim
        logic unused_high_bits;
        assign unused_high_bits = ^req_wdata[DATA_W-1:NUM_VP];
    end

    vprc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .cmd       (cmd)
    );

    for (genvar i = 0; i < NUM_VP; i++) begin : g_slot
        vprc_slot #(.START_ON_RESET(START_MASK[i])) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_cmd (cmd.start_wr & vp_mask[i]),
            .halt_cmd  (cmd.halt_wr & vp_mask[i]),
            .ack       (reset_ack[i]),
            .reset_req (reset_req[i]),
            .run_en    (run_en[i]),
            .halt_req  (halt_req[i])
        );
    end

    vprc_readback #(.NUM_VP(NUM_VP), .DATA_W(DATA_W)) u_readback (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .running   (run_en),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/vprc_checker.sv
// Module: assertion checker for vp_run_ctrl, attached by bind.
// Relates bus requests, handshake inputs and per-processor outputs over time.
module vprc_checker #(
    parameter int NUM_VP = 1,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [NUM_VP-1:0] reset_ack,
    input logic [NUM_VP-1:0] reset_req,
    input logic [NUM_VP-1:0] run_en,
    input logic [NUM_VP-1:0] halt_req
);
    logic status_hit_q;

    // Purpose: remember whether the previous request addressed status.
    always_ff @(posedge clk) begin
        if (!rst_n) status_hit_q <= 1'b0;
        else        status_hit_q <= req_valid && !req_write &&
                                    ((req_addr >> 8) < ADDR_W'(2)) &&
                                    (req_addr[7:0] == 8'h10);
    end

    p_halt_from_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req & ~$past(run_en)) == '0);

    p_halt_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req & (run_en | reset_req)) == '0);

    p_run_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en & ~$past(run_en) & ~($past(reset_ack) & $past(reset_req))) == '0);

    p_running_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_en) & ~run_en & ~halt_req) == '0);

    p_rsp_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    p_no_stray_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !status_hit_q) |-> (rsp_rdata == '0));

    p_status_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_rdata >> NUM_VP) == '0));

endmodule

bind vp_run_ctrl vprc_checker #(
    .NUM_VP (NUM_VP),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .reset_ack (reset_ack),
    .reset_req (reset_req),
    .run_en    (run_en),
    .halt_req  (halt_req)
);

// File: tb/vp_run_ctrl_tb.sv
// Directed bench for vp_run_ctrl: one task per scenario, each self-checking.
module vp_run_ctrl_tb;
    localparam int          NUM_VP = 4;
    localparam logic [63:0] SMASK  = 64'h5;
    localparam int          ADDR_W = 12;
    localparam int          DATA_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic [NUM_VP-1:0] reset_ack = '0;
    logic [NUM_VP-1:0] reset_req;
    logic [NUM_VP-1:0] run_en;
    logic [NUM_VP-1:0] halt_req;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    vp_run_ctrl #(.NUM_VP(NUM_VP), .START_MASK(SMASK),
                  .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .reset_ack(reset_ack),
        .reset_req(reset_req), .run_en(run_en), .halt_req(halt_req)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One bus write; returns at the negedge after the accepting posedge.
    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [63:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // One bus read; checks rsp_valid and returns the data.
    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [63:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R5 rsp_valid", {63'b0, rsp_valid}, 64'h1);
        d = rsp_rdata;
    endtask

    task automatic pulse_ack(input logic [NUM_VP-1:0] m);
        reset_ack = m;
        @(negedge clk);
        reset_ack = '0;
    endtask

    task automatic t_reset_start;
        logic [63:0] d;
        check("R7 reset_req after reset", 64'(reset_req), 64'h5);
        check("R7 run_en after reset", 64'(run_en), 64'h0);
        bus_read(12'h010, d);
        check("R7 status after reset", d, 64'h0);
        repeat (3) @(negedge clk);
        check("R3 reset_req held without ack", 64'(reset_req), 64'h5);
        pulse_ack(4'h5);
        check("R3 run_en after ack", 64'(run_en), 64'h5);
        check("R3 reset_req drops on ack", 64'(reset_req), 64'h0);
        bus_read(12'h010, d);
        check("R5 status read", d, 64'h5);
    endtask

    task automatic t_start_masked;
        bus_write(12'h000, 64'hF3);
        check("R1 R2 start only idle in-range", 64'(reset_req), 64'h2);
        check("R2 running untouched", 64'(run_en), 64'h5);
        bus_write(12'h100, 64'h2);
        check("R9 repeat start while pending", 64'(reset_req), 64'h2);
        check("R9 no other change", 64'(run_en), 64'h5);
        pulse_ack(4'h2);
        check("R3 second start completes", 64'(run_en), 64'h7);
    endtask

    task automatic t_halt;
        logic [63:0] d;
        bus_write(12'h108, 64'h31);
        check("R4 halt pulse", 64'(halt_req), 64'h1);
        check("R4 R6 run_en cleared", 64'(run_en), 64'h6);
        @(negedge clk);
        check("R4 halt is one cycle", 64'(halt_req), 64'h0);
        bus_write(12'h008, 64'h8);
        check("R4 halt on idle no pulse", 64'(halt_req), 64'h0);
        bus_read(12'h110, d);
        check("R6 status via alternate window", d, 64'h6);
    endtask

    task automatic t_unmapped;
        logic [63:0] d;
        bus_write(12'h018, 64'hF);
        check("R8 unmapped offset write", 64'(reset_req), 64'h0);
        bus_write(12'h200, 64'hF);
        check("R8 third window write", 64'(reset_req), 64'h0);
        check("R8 running unchanged", 64'(run_en), 64'h6);
        bus_read(12'h008, d);
        check("R8 read halt offset", d, 64'h0);
        bus_read(12'h118, d);
        check("R8 read unmapped", d, 64'h0);
        bus_read(12'h210, d);
        check("R8 read status offset outside windows", d, 64'h0);
    endtask

    task automatic t_cancel;
        bus_write(12'h100, 64'h8);
        check("R2 start idle vp3", 64'(reset_req), 64'h8);
        bus_write(12'h008, 64'h8);
        check("R10 cancel drops reset_req", 64'(reset_req), 64'h0);
        check("R10 cancel no halt", 64'(halt_req), 64'h0);
        pulse_ack(4'h8);
        check("R10 late ack ignored", 64'(run_en), 64'h6);
    endtask

    task automatic run_all;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_start();
        t_start_masked();
        t_halt();
        t_unmapped();
        t_cancel();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog (all requirements): actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule